// File: doc/BRIEF.md
# Privileged 64-bit Configuration Register File

This block holds a small bank of 64-bit configuration and status registers that sit behind a 32-bit register index. A requester presents one command per cycle: a read or a write, the target index, the privilege level of the issuing context and, for writes, the data split into a high 32-bit word and a low 32-bit word. Exactly one cycle later the block answers with a response strobe, a fault flag and, for a successful read, the 64-bit contents returned as two 32-bit halves.

Every command is screened before it touches state. The checks are: the privilege level, whether the index maps to a register, reserved bits in the write data, and whether a lock is in force. Each register has one of four access kinds. A read-only capability word drops writes silently. A read-write configuration word takes whatever is written. An error log is set by hardware event pulses and cleared by writing ones. A lock control word holds a sticky lock bit, and once that bit is set the protected registers refuse further writes until reset. A write that passes the checks lands all 64 bits on one clock edge.

Top module: `cfg_regfile`

## Requirements
- R1: After reset the response strobe is low, and every writable register (configuration, error log, lock control, protected) reads as zero.
- R2: With the default base index 0x600, the register indices are: 0x600 read-only capability, 0x601 read-write configuration, 0x602 write-1-to-clear error log, 0x603 lock control, 0x604 and 0x605 protected registers.
- R3: Any command whose privilege level is not 0 is answered with a fault, and no register changes.
- R4: A command to an index outside base..base+5 is answered with a fault, whether it is a read or a write.
- R5: A write that sets a reserved bit is answered with a fault and leaves the target unchanged. The reserved bits are 63:48 for configuration, 63:32 for the error log, 63:8 for lock control and bit 63 for the protected registers.
- R6: The capability register reads as the parameter value 0xC0DE_0002_0000_1234. A privileged write to it draws no fault and changes nothing.
- R7: Writing the error log clears each bit written as 1 and keeps each bit written as 0. Event pulses set log bits, excluding reserved bits, on every edge, and a set wins over a clear of the same bit on the same edge.
- R8: Bit 0 of lock control is the lock. While it is 1, writes to the protected registers fault and change nothing. Only reset clears the lock, while the other lock-control bits stay writable.
- R9: Every command is answered by a response strobe in the cycle after it is presented, and a cycle with no command gives no strobe. Read data comes back as a high word (bits 63:32) and a low word (bits 31:0). The response to a write carries zero data.
- R10: A faulting response always carries zero read data.
- R11: A successful write updates both 32-bit halves on the same edge, so a read in the next cycle returns the complete new 64-bit value.
- R12: The read-write configuration register returns exactly the last value written to it without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_index | input | 32 | Register index |
| req_cpl | input | 2 | Privilege level of the requester |
| req_wdata_hi | input | 32 | Write data bits 63:32 |
| req_wdata_lo | input | 32 | Write data bits 31:0 |
| evt_set | input | 64 | Hardware event pulses that set error-log bits |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Command rejected |
| rsp_rdata_hi | output | 32 | Read data bits 63:32 |
| rsp_rdata_lo | output | 32 | Read data bits 31:0 |

## Verification
The main function, guarded register access, is tried with write values whose two halves differ. A swap of the halves or a one-word update would show up in the read that follows. Each check is driven both at privilege 0 and at a non-zero level, and both inside and just outside the index window, so a missing guard can be told apart from a wrong decode. On the error log, clears are mixed with event pulses on the same edge, which shows whether a set beats a clear. On the protected registers, writes are issued before and after the lock is set. A write of zero to the lock then shows whether the lock can be undone without reset.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_RO,
    KIND_RW,
    KIND_W1C,
    KIND_LOCKCTL,
    KIND_PROT
  } reg_kind_e;

  localparam int unsigned FIXED_SLOTS = 4;
  localparam int unsigned SLOT_CAPS   = 0;
  localparam int unsigned SLOT_CFG    = 1;
  localparam int unsigned SLOT_LOG    = 2;
  localparam int unsigned SLOT_LOCK   = 3;
  localparam int unsigned SLOT_PROT0  = 4;
  localparam int unsigned LOCK_BIT    = 0;

  function automatic reg_kind_e kind_of_slot(input int unsigned s);
    reg_kind_e k;
    case (s)
      SLOT_CAPS: k = KIND_RO;
      SLOT_CFG:  k = KIND_RW;
      SLOT_LOG:  k = KIND_W1C;
      SLOT_LOCK: k = KIND_LOCKCTL;
      default:   k = KIND_PROT;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/cfgrf_decode.sv
module cfgrf_decode
  import cfgrf_pkg::*;
#(
  parameter logic [31:0] BASE_IDX     = 32'h0000_0600,
  parameter int unsigned NUM_SLOTS    = 6,
  parameter int unsigned SLOT_W       = 3,
  parameter logic [63:0] CFG_RSV      = 64'hFFFF_0000_0000_0000,
  parameter logic [63:0] LOG_RSV      = 64'hFFFF_FFFF_0000_0000,
  parameter logic [63:0] LOCK_RSV     = 64'hFFFF_FFFF_FFFF_FF00,
  parameter logic [63:0] PROT_RSV     = 64'h8000_0000_0000_0000
) (
  input  logic [31:0]       index,
  output logic              hit,
  output logic [SLOT_W-1:0] slot,
  output reg_kind_e         kind,
  output logic [63:0]       rsv_mask
);

  logic [31:0] offset;

  always_comb begin
    offset = index - BASE_IDX;
    hit    = (offset < NUM_SLOTS);
    slot   = offset[SLOT_W-1:0];
    if (hit) kind = kind_of_slot(int'(slot));
    else     kind = KIND_NONE;
    case (kind)
      KIND_RW:      rsv_mask = CFG_RSV;
      KIND_W1C:     rsv_mask = LOG_RSV;
      KIND_LOCKCTL: rsv_mask = LOCK_RSV;
      KIND_PROT:    rsv_mask = PROT_RSV;
      default:      rsv_mask = '0;
    endcase
  end

endmodule

// File: rtl/cfgrf_check.sv
module cfgrf_check
  import cfgrf_pkg::*;
(
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  input  logic        hit,
  input  reg_kind_e   kind,
  input  logic [63:0] rsv_mask,
  input  logic [63:0] wdata,
  input  logic        lock_q,
  output logic        fault,
  output logic        wr_en,
  output logic        rd_en
);

  logic priv_bad;
  logic rsv_bad;
  logic lock_bad;

  always_comb begin
    priv_bad = (req_cpl != 2'd0);
    rsv_bad  = req_write && (kind != KIND_RO) && ((wdata & rsv_mask) != '0);
    lock_bad = req_write && (kind == KIND_PROT) && lock_q;
    fault    = req_valid && (priv_bad || !hit || rsv_bad || lock_bad);
    wr_en    = req_valid && req_write && !fault && (kind != KIND_RO);
    rd_en    = req_valid && !req_write && !fault;
  end

endmodule

// File: rtl/cfgrf_bank.sv
module cfgrf_bank
  import cfgrf_pkg::*;
#(
  parameter int unsigned NUM_LOCKABLE = 2,
  parameter int unsigned SLOT_W       = 3,
  parameter logic [63:0] CAPS_VALUE   = 64'hC0DE_0002_0000_1234,
  parameter logic [63:0] LOG_RSV      = 64'hFFFF_FFFF_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [63:0]       wdata,
  input  logic [63:0]       evt_set,
  output logic [63:0]       rdata,
  output logic              lock_q
);

  localparam logic [SLOT_W-1:0] S_CFG  = SLOT_W'(SLOT_CFG);
  localparam logic [SLOT_W-1:0] S_LOG  = SLOT_W'(SLOT_LOG);
  localparam logic [SLOT_W-1:0] S_LOCK = SLOT_W'(SLOT_LOCK);
  localparam logic [SLOT_W-1:0] S_CAPS = SLOT_W'(SLOT_CAPS);

  logic [63:0] cfg_q,  cfg_d;
  logic [63:0] log_q,  log_d;
  logic [63:0] lctl_q, lctl_d;
  logic [63:0] prot_q [NUM_LOCKABLE];
  logic [63:0] prot_d [NUM_LOCKABLE];
  logic        cfg_en, log_wr, lctl_en;

  // next-state for the fixed registers
  always_comb begin
    cfg_en  = wr_en && (slot == S_CFG);
    log_wr  = wr_en && (slot == S_LOG);
    lctl_en = wr_en && (slot == S_LOCK);
    cfg_d   = cfg_en ? wdata : cfg_q;
    log_d   = (log_q & ~(log_wr ? wdata : 64'd0)) | (evt_set & ~LOG_RSV);
    lctl_d  = lctl_q;
    if (lctl_en) begin
      lctl_d           = wdata;
      lctl_d[LOCK_BIT] = wdata[LOCK_BIT] | lctl_q[LOCK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      log_q  <= '0;
      lctl_q <= '0;
    end else begin
      if (cfg_en)  cfg_q  <= cfg_d;
      log_q <= log_d;
      if (lctl_en) lctl_q <= lctl_d;
    end
  end

  assign lock_q = lctl_q[LOCK_BIT];

  // protected registers, one per lockable slot
  for (genvar g = 0; g < NUM_LOCKABLE; g++) begin : g_prot
    localparam logic [SLOT_W-1:0] S_ME = SLOT_W'(SLOT_PROT0 + g);
    logic en;

    always_comb begin
      en        = wr_en && (slot == S_ME);
      prot_d[g] = en ? wdata : prot_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prot_q[g] <= '0;
      else if (en) prot_q[g] <= prot_d[g];
    end

    // R8: a set lock freezes every protected register
    a_r8_prot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(prot_q[g]));
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (slot == S_CAPS) rdata = CAPS_VALUE;
    if (slot == S_CFG)  rdata = cfg_q;
    if (slot == S_LOG)  rdata = log_q;
    if (slot == S_LOCK) rdata = lctl_q;
    for (int i = 0; i < NUM_LOCKABLE; i++) begin
      if (slot == SLOT_W'(SLOT_PROT0 + i)) rdata = prot_q[i];
    end
  end

  // R8: lock stays set until reset
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R7: bits written as 1 are clear afterwards unless an event re-set them
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    log_wr |=> ((log_q & $past(wdata) & ~$past(evt_set)) == 64'd0));

  // R7: bits written as 0 are never lost
  a_r7_w1c_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    log_wr |=> (($past(log_q) & ~$past(wdata) & ~log_q) == 64'd0));

  // R5: reserved log bits never become set
  a_r5_log_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q & LOG_RSV) == 64'd0);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfgrf_pkg::*;
#(
  parameter logic [31:0] BASE_IDX     = 32'h0000_0600,
  parameter int unsigned NUM_LOCKABLE = 2,
  parameter logic [63:0] CAPS_VALUE   = 64'hC0DE_0002_0000_1234,
  parameter logic [63:0] CFG_RSV      = 64'hFFFF_0000_0000_0000,
  parameter logic [63:0] LOG_RSV      = 64'hFFFF_FFFF_0000_0000,
  parameter logic [63:0] LOCK_RSV     = 64'hFFFF_FFFF_FFFF_FF00,
  parameter logic [63:0] PROT_RSV     = 64'h8000_0000_0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_index,
  input  logic [1:0]  req_cpl,
  input  logic [31:0] req_wdata_hi,
  input  logic [31:0] req_wdata_lo,
  input  logic [63:0] evt_set,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_rdata_hi,
  output logic [31:0] rsp_rdata_lo
);

  localparam int unsigned NUM_SLOTS = FIXED_SLOTS + NUM_LOCKABLE;
  localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [63:0]       wdata;
  logic              hit;
  logic [SLOT_W-1:0] slot;
  reg_kind_e         kind;
  logic [63:0]       rsv_mask;
  logic              lock_q;
  logic              fault, wr_en, rd_en;
  logic [63:0]       bank_rdata;

  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_fault_q, rsp_fault_d;
  logic [63:0]       rsp_data_q,  rsp_data_d;

  assign wdata = {req_wdata_hi, req_wdata_lo};

  cfgrf_decode #(
    .BASE_IDX (BASE_IDX),
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .CFG_RSV  (CFG_RSV),
    .LOG_RSV  (LOG_RSV),
    .LOCK_RSV (LOCK_RSV),
    .PROT_RSV (PROT_RSV)
  ) u_decode (
    .index   (req_index),
    .hit     (hit),
    .slot    (slot),
    .kind    (kind),
    .rsv_mask(rsv_mask)
  );

  cfgrf_check u_check (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_cpl  (req_cpl),
    .hit      (hit),
    .kind     (kind),
    .rsv_mask (rsv_mask),
    .wdata    (wdata),
    .lock_q   (lock_q),
    .fault    (fault),
    .wr_en    (wr_en),
    .rd_en    (rd_en)
  );

  cfgrf_bank #(
    .NUM_LOCKABLE(NUM_LOCKABLE),
    .SLOT_W      (SLOT_W),
    .CAPS_VALUE  (CAPS_VALUE),
    .LOG_RSV     (LOG_RSV)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .slot   (slot),
    .wdata  (wdata),
    .evt_set(evt_set),
    .rdata  (bank_rdata),
    .lock_q (lock_q)
  );

  // response next-state
  always_comb begin
    rsp_valid_d = req_valid;
    rsp_fault_d = fault;
    rsp_data_d  = rd_en ? bank_rdata : 64'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_fault_q <= rsp_fault_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_fault    = rsp_fault_q;
  assign rsp_rdata_hi = rsp_data_q[63:32];
  assign rsp_rdata_lo = rsp_data_q[31:0];

  // R3: an unprivileged command never writes and is answered with a fault
  a_r3_priv_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cpl != 2'd0) |-> !wr_en);
  a_r3_priv_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cpl != 2'd0) |=> (rsp_valid && rsp_fault));

  // R4: an index outside the window faults
  a_r4_unmapped_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_index - BASE_IDX) >= NUM_SLOTS)) |=> rsp_fault);

  // R9: one response per command, in the following cycle
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R10: a fault carries no data
  a_r10_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_rdata_hi == 32'd0 && rsp_rdata_lo == 32'd0));

  // R6: privileged write to the read-only word draws no fault
  a_r6_ro_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_cpl == 2'd0 && req_index == BASE_IDX) |=> !rsp_fault);

endmodule

// File: tb/tb_cfg_regfile.sv
`timescale 1ns/1ps
module tb_cfg_regfile;

  localparam logic [31:0] BASE   = 32'h0000_0600;
  localparam logic [63:0] CAPS   = 64'hC0DE_0002_0000_1234;
  localparam logic [63:0] M_CFG  = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] M_LOG  = 64'hFFFF_FFFF_0000_0000;
  localparam logic [63:0] M_LOCK = 64'hFFFF_FFFF_FFFF_FF00;
  localparam logic [63:0] M_PROT = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_index;
  logic [1:0]  req_cpl;
  logic [31:0] req_wdata_hi, req_wdata_lo;
  logic [63:0] evt_set;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_rdata_hi, rsp_rdata_lo;

  always #2.5 clk = ~clk;

  cfg_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
    .req_cpl(req_cpl), .req_wdata_hi(req_wdata_hi), .req_wdata_lo(req_wdata_lo),
    .evt_set(evt_set),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rdata_hi(rsp_rdata_hi), .rsp_rdata_lo(rsp_rdata_lo)
  );

  int checks = 0;
  int failures = 0;
  bit armed = 0;
  bit done = 0;

  // behavioural reference state
  logic [63:0] m_reg [6];
  logic        e_valid, e_fault;
  logic [63:0] e_data;
  string       e_tag;

  // compare every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (armed && !done) begin
      checks++;
      if (rsp_valid !== e_valid || rsp_fault !== e_fault ||
          {rsp_rdata_hi, rsp_rdata_lo} !== e_data) begin
        failures++;
        $display("FAIL %s: got valid=%0b fault=%0b data=%h, expected valid=%0b fault=%0b data=%h",
                 e_tag, rsp_valid, rsp_fault, {rsp_rdata_hi, rsp_rdata_lo},
                 e_valid, e_fault, e_data);
      end
    end
  end

  // one cycle of stimulus plus the expected response for it
  task automatic cyc(input bit v, input bit w, input logic [31:0] idx,
                     input logic [1:0] cpl, input logic [63:0] d,
                     input logic [63:0] evt, input string tag);
    logic [31:0] off;
    bit          hit, flt;
    logic [63:0] rsv;
    @(negedge clk);
    req_valid = v; req_write = w; req_index = idx; req_cpl = cpl;
    {req_wdata_hi, req_wdata_lo} = d; evt_set = evt;
    off = idx - BASE;
    hit = (off < 6);
    case (off)
      1: rsv = M_CFG;
      2: rsv = M_LOG;
      3: rsv = M_LOCK;
      4, 5: rsv = M_PROT;
      default: rsv = 64'd0;
    endcase
    flt = v && (cpl != 0 || !hit ||
               (w && off != 0 && (d & rsv) != 0) ||
               (w && (off == 4 || off == 5) && m_reg[3][0]));
    e_valid = v;
    e_fault = flt;
    e_data  = (v && !w && !flt) ? (off == 0 ? CAPS : m_reg[off]) : 64'd0;
    e_tag   = tag;
    if (v && w && !flt) begin
      case (off)
        1, 4, 5: m_reg[off] = d;
        2:       m_reg[2] = m_reg[2] & ~d;
        3:       m_reg[3] = d | {63'd0, m_reg[3][0]};
        default: ;
      endcase
    end
    m_reg[2] = m_reg[2] | (evt & ~M_LOG);
    armed = 1;
  endtask

  task automatic rd(input int off, input string tag);
    cyc(1, 0, BASE + off, 0, 64'd0, 64'd0, tag);
  endtask
  task automatic wr(input int off, input logic [63:0] d, input string tag);
    cyc(1, 1, BASE + off, 0, d, 64'd0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 32'd0, 0, 64'd0, 64'd0, tag);
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_reg[i] = 64'd0;
    rst_n = 0; req_valid = 0; req_write = 0; req_index = 0; req_cpl = 0;
    req_wdata_hi = 0; req_wdata_lo = 0; evt_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, R2 map, R6 capability value
    idle("R1 no response after reset");
    idle("R1 no response after reset");
    for (int i = 0; i < 6; i++) rd(i, "R1 R2 reset contents");

    // R12 / R11 read-write register with distinct halves
    wr(1, 64'h0000_1234_89AB_CDEF, "R9 write response");
    rd(1, "R12 R11 readback");
    wr(1, 64'h0000_FFFF_0000_0001, "R9 write response");
    rd(1, "R11 both halves");
    idle("R9 idle cycle");

    // R5 reserved bits
    wr(1, 64'h8000_0000_0000_0000, "R5 cfg reserved");
    rd(1, "R5 cfg unchanged");

    // R3 privilege
    cyc(1, 1, BASE + 1, 3, 64'h0000_0000_0000_0055, 0, "R3 unprivileged write");
    rd(1, "R3 state unchanged");
    cyc(1, 0, BASE + 1, 1, 0, 0, "R3 R10 unprivileged read");
    cyc(1, 1, BASE, 2, 64'd1, 0, "R3 unprivileged write to read-only");

    // R4 unmapped
    rd(6, "R4 index above window");
    cyc(1, 1, BASE - 1, 0, 64'd7, 0, "R4 index below window");
    cyc(1, 0, 32'd0, 0, 0, 0, "R4 index zero");

    // R6 read-only ignores write
    wr(0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 write ignored, no fault");
    rd(0, "R6 capability unchanged");

    // R7 write-1-to-clear log
    cyc(0, 0, 0, 0, 0, 64'hFFFF_0000_00F0_00FF, "R7 event pulse");
    rd(2, "R7 events set unreserved bits");
    wr(2, 64'h0000_0000_0000_000F, "R7 clear low nibble");
    rd(2, "R7 ones clear, zeros keep");
    cyc(1, 1, BASE + 2, 0, 64'h0000_0000_0000_0030, 64'h0000_0000_0000_0010, "R7 set beats clear");
    rd(2, "R7 after set/clear race");
    wr(2, 64'h0000_0001_0000_0000, "R5 log reserved");
    rd(2, "R5 log unchanged");

    // R8 lock
    wr(4, 64'h1111_2222_3333_4444, "R8 protected write before lock");
    wr(5, 64'h0555_6666_7777_8888, "R8 protected write before lock");
    rd(4, "R8 prot0 readback");
    rd(5, "R8 prot1 readback");
    wr(4, 64'hF000_0000_0000_0000, "R5 protected reserved");
    wr(3, 64'h0000_0000_0000_0081, "R8 set lock");
    rd(3, "R8 lock control");
    wr(4, 64'h0000_0000_0000_0001, "R8 write blocked by lock");
    rd(4, "R8 prot0 unchanged");
    wr(5, 64'h0000_0000_0000_0002, "R8 write blocked by lock");
    rd(5, "R8 prot1 unchanged");
    wr(3, 64'h0000_0000_0000_0040, "R8 lock cannot be cleared");
    rd(3, "R8 lock held, other bits writable");
    wr(3, 64'h0000_0000_0000_0100, "R5 lock control reserved");
    rd(3, "R5 lock control unchanged");

    // R9 back-to-back
    wr(1, 64'h0000_ABCD_0000_1234, "R9 back-to-back write");
    rd(1, "R9 R11 back-to-back read");
    rd(0, "R9 back-to-back read");
    idle("R9 idle after traffic");
    idle("R9 idle after traffic");

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule